// File: doc/BRIEF.md
# Packed Six-Channel TDM Audio Deserializer

This block sits on the receive side of a packed six-channel audio link. It takes three external signals: a bit clock, a framing clock and one serial data line. All three are brought into a faster system clock through one shared synchronizer, so they stay aligned with each other. The block detects bit-clock rising edges in the system domain and samples data and framing on each one. It then rebuilds the six audio words of a frame in one of two packed layouts: a 128-bit frame or a 256-bit frame.

The receiver is told the layout and the word length on static inputs that match the transmitter's settings. A frame begins at the framing-clock transition that opens the left group. That transition is a rise in the 128-bit layout and a fall in the 256-bit layout. The layout sets where each word lies inside its slot, which gap slots are skipped and whether a one-bit delay comes before the MSB. When a frame completes, all six words are presented together, sign-extended to 24 bits, and a single-cycle valid strobe is raised. A framing-error strobe reports frames of the wrong length. The layout and the word length are meant to change only while reset is held.

Top module: `tdm6_deser`

## Requirements
- R1: While reset is held and in the first cycle after it, `valid_o` and `frame_err_o` are low and `smp_o` is all zeros.
- R2: With `mode256_i`=0, a frame is 128 bit-clock periods long. The frame starts at the first bit-clock rise where the sampled framing clock is high after having been low. That rise is bit 0. The left words occupy bits 0-19, 20-39 and 40-59, bits 60-63 form a gap, the right words occupy bits 64-83, 84-103 and 104-123, and bits 124-127 form a gap. Each word's MSB is at the first bit of its slot, and data is sampled on bit-clock rises.
- R3: `wlen_i` selects the word length: 0 gives 16 bits, 1 gives 20 bits, and 2 or 3 gives 24 bits. Words arrive MSB first and are sign-extended from their length to 24 bits.
- R4: With `mode256_i`=0, a 24-bit selection is limited to 20 bits.
- R5: With `mode256_i`=1, a frame is 256 periods long and starts at the first rise where the sampled framing clock is low after having been high. It has 32-bit slots in the order left 0, left 1, left 2, gap, right 0, right 1, right 2, gap. Each word's MSB is at the second bit of its slot.
- R6: `smp_o[24*k +: 24]` holds channel k, with k=0..5 in the order left 0, left 1, left 2, right 0, right 1, right 2. All six channels change in the same cycle. `valid_o` is high for exactly that one cycle, once per frame, after the last bit of the right 2 slot. At all other times `smp_o` holds its value.
- R7: Data-line values in gap slots, in the delay bit and in slot bits after the word has no effect on `smp_o`.
- R8: A left-group start transition that arrives before the terminal bit (127 or 255) of a counted frame gives a one-cycle `frame_err_o`. The partly received frame produces no `valid_o`, and counting restarts at bit 0.
- R9: A bit-clock rise after the terminal bit that is not a left-group start gives a one-cycle `frame_err_o`, and the block stops counting. The next start transition is then accepted without error. Before the first start transition after reset, no bits are counted and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Asynchronous serial bit clock |
| lrclk_i | input | 1 | Asynchronous framing clock |
| sdata_i | input | 1 | Serial data, launched on bit-clock falls |
| mode256_i | input | 1 | 0: 128-bit frame layout, 1: 256-bit frame layout |
| wlen_i | input | 2 | Word length code (0:16, 1:20, 2/3:24) |
| smp_o | output | 144 | Six sign-extended 24-bit samples, channel k at bits 24k+23..24k |
| valid_o | output | 1 | One-cycle strobe when a new frame of samples is presented |
| frame_err_o | output | 1 | One-cycle strobe on a frame of the wrong length |

## Verification
A wrong bit position inside the frame counter shows up as shifted or swapped channel words at the next valid strobe. That happens at most one frame after the fault, because each channel's word is checked against a value rebuilt from the layout rules. If the counter loses lock or keeps it when it should not, the evidence is a missing valid strobe or an extra or missing error strobe within the frame that follows. Gap slots and unused slot bits are driven with ones on purpose, so that a capture window that is one bit too wide or one bit early changes the low bits of the sign-extended words.

// File: rtl/tdm6_pkg.sv
package tdm6_pkg;
  localparam int unsigned POS_W   = 8;
  localparam int unsigned N_CH    = 6;
  localparam int unsigned WB_W    = 5;
  localparam int unsigned SLOT128 = 20;
  localparam logic [POS_W-1:0] TC128   = 8'd127;
  localparam logic [POS_W-1:0] TC256   = 8'd255;
  localparam logic [POS_W-1:0] LAST128 = 8'd123;
  localparam logic [POS_W-1:0] LAST256 = 8'd223;

  typedef enum logic [1:0] {WL16 = 2'd0, WL20 = 2'd1, WL24 = 2'd2, WL24X = 2'd3} wlen_e;

  // effective word length; the 128-bit layout cannot carry more than 20 bits
  function automatic logic [WB_W-1:0] wlen_bits(input logic [1:0] code, input logic m256);
    case (wlen_e'(code))
      WL16:    wlen_bits = 5'd16;
      WL20:    wlen_bits = 5'd20;
      default: wlen_bits = m256 ? 5'd24 : 5'd20;
    endcase
  endfunction
endpackage

// File: rtl/tdm6_sync.sv
module tdm6_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= '0;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tdm6_frame_ctl.sv
module tdm6_frame_ctl
  import tdm6_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             lr_bit,
  input  logic             mode256,
  output logic [POS_W-1:0] cur_pos,
  output logic             act,
  output logic             frame_err
);
  logic             lr_prev, lr_seen, locked;
  logic [POS_W-1:0] pos_q;
  logic             start_edge, at_tc;

  always_comb begin
    start_edge = bit_stb & lr_seen &
                 (mode256 ? (lr_prev & ~lr_bit) : (~lr_prev & lr_bit));
    at_tc   = (pos_q == (mode256 ? TC256 : TC128));
    act     = start_edge | (bit_stb & locked & ~at_tc);
    cur_pos = start_edge ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_prev   <= 1'b0;
      lr_seen   <= 1'b0;
      locked    <= 1'b0;
      pos_q     <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (bit_stb) begin
        lr_prev <= lr_bit;
        lr_seen <= 1'b1;
        if (start_edge) begin
          pos_q     <= '0;
          locked    <= 1'b1;
          frame_err <= locked & ~at_tc;
        end else if (locked) begin
          if (at_tc) begin
            locked    <= 1'b0;
            frame_err <= 1'b1;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdm6_slot_map.sv
module tdm6_slot_map
  import tdm6_pkg::*;
(
  input  logic [POS_W-1:0] pos,
  input  logic             mode256,
  input  logic [1:0]       wlen,
  output logic             cap,
  output logic [2:0]       ch,
  output logic             last
);
  logic            half;
  logic [1:0]      slot;
  logic [5:0]      off;
  logic [5:0]      h;
  logic [WB_W-1:0] wb;

  always_comb begin
    wb = wlen_bits(wlen, mode256);
    if (mode256) begin
      half = pos[7];
      slot = pos[6:5];
      off  = {1'b0, pos[4:0]};
      cap  = (slot != 2'd3) && (off != 6'd0) && (off <= {1'b0, wb});
      h    = '0;
    end else begin
      half = pos[6];
      h    = pos[5:0];
      if (h < 6'(SLOT128)) begin
        slot = 2'd0; off = h;
      end else if (h < 6'(2*SLOT128)) begin
        slot = 2'd1; off = h - 6'(SLOT128);
      end else if (h < 6'(3*SLOT128)) begin
        slot = 2'd2; off = h - 6'(2*SLOT128);
      end else begin
        slot = 2'd3; off = h - 6'(3*SLOT128);
      end
      cap = (slot != 2'd3) && (off < {1'b0, wb});
    end
    ch   = half ? ({1'b0, slot} + 3'd3) : {1'b0, slot};
    last = (pos == (mode256 ? LAST256 : LAST128));
  end
endmodule

// File: rtl/tdm6_deser.sv
module tdm6_deser
  import tdm6_pkg::*;
#(
  parameter int unsigned SMP_W       = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bclk_i,
  input  logic                    lrclk_i,
  input  logic                    sdata_i,
  input  logic                    mode256_i,
  input  logic [1:0]              wlen_i,
  output logic [N_CH*SMP_W-1:0]   smp_o,
  output logic                    valid_o,
  output logic                    frame_err_o
);
  logic [2:0]       syn;
  logic             b_d, bit_stb;
  logic [POS_W-1:0] cur_pos;
  logic             act, cap, last, done_q, valid_q;
  logic [2:0]       ch;
  logic [WB_W-1:0]  wb;
  logic [SMP_W-1:0] shd [N_CH];

  tdm6_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d({bclk_i, lrclk_i, sdata_i}), .q(syn)
  );

  always_ff @(posedge clk) begin
    if (rst) b_d <= 1'b0;
    else     b_d <= syn[2];
  end
  assign bit_stb = syn[2] & ~b_d;

  tdm6_frame_ctl i_ctl (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .lr_bit(syn[1]),
    .mode256(mode256_i), .cur_pos(cur_pos), .act(act), .frame_err(frame_err_o)
  );

  tdm6_slot_map i_map (
    .pos(cur_pos), .mode256(mode256_i), .wlen(wlen_i),
    .cap(cap), .ch(ch), .last(last)
  );

  assign wb = wlen_bits(wlen_i, mode256_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      done_q  <= act & last;
      valid_q <= done_q;
    end
  end
  assign valid_o = valid_q;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic [SMP_W-1:0] ext;
    logic [SMP_W-1:0] out_q;

    always_ff @(posedge clk) begin
      if (rst)
        shd[k] <= '0;
      else if (act && cap && (ch == 3'(k)))
        shd[k] <= {shd[k][SMP_W-2:0], syn[0]};
    end

    always_comb begin
      for (int i = 0; i < SMP_W; i++)
        ext[i] = (i < int'(wb)) ? shd[k][i] : shd[k][wb - 1'b1];
    end

    always_ff @(posedge clk) begin
      if (rst)         out_q <= '0;
      else if (done_q) out_q <= ext;
    end

    assign smp_o[k*SMP_W +: SMP_W] = out_q;
  end
endmodule

// File: rtl/tdm6_deser_chk.sv
module tdm6_deser_chk #(
  parameter int unsigned SMP_W = 24,
  parameter int unsigned N_CH  = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  valid_o,
  input logic                  frame_err_o,
  input logic [N_CH*SMP_W-1:0] smp_o,
  input logic [1:0]            wlen_i
);
  // R1
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && !frame_err_o && smp_o == '0));

  // R6
  a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R6
  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !$past(rst)) |-> $stable(smp_o));

  // R8
  a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> !frame_err_o);

  // R8
  a_r8_err_not_with_valid: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> !valid_o);

  for (genvar k = 0; k < N_CH; k++) begin : g_sx
    // R3
    a_r3_sign_ext16: assert property (@(posedge clk) disable iff (rst)
      (valid_o && wlen_i == 2'd0) |->
        (smp_o[k*SMP_W+16 +: SMP_W-16] == {(SMP_W-16){smp_o[k*SMP_W+15]}}));
  end
endmodule

bind tdm6_deser tdm6_deser_chk #(.SMP_W(SMP_W), .N_CH(6)) i_chk (
  .clk(clk), .rst(rst), .valid_o(valid_o), .frame_err_o(frame_err_o),
  .smp_o(smp_o), .wlen_i(wlen_i)
);

// File: tb/test_tdm6_deser.sv
module test_tdm6_deser;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bclk = 1'b0, lrclk = 1'b0, sdat = 1'b0;
  logic         m256 = 1'b0;
  logic [1:0]   wl = 2'd0;
  logic [143:0] smp;
  logic         valid, ferr;

  int checks = 0, errors = 0;
  int vcnt = 0, ecnt = 0, dbl = 0;
  logic         vprev = 1'b0;
  logic [143:0] got = '0;
  bit           finished = 0;

  always #10 clk = ~clk;

  tdm6_deser i_tdm6_deser (
    .clk(clk), .rst(rst), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdat),
    .mode256_i(m256), .wlen_i(wl), .smp_o(smp), .valid_o(valid), .frame_err_o(ferr)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (valid) begin vcnt++; got = smp; end
      if (valid && vprev) dbl++;
      if (ferr) ecnt++;
    end
    vprev = valid;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int wbits(input bit mm, input logic [1:0] w);
    if (w == 2'd0) return 16;
    if (w == 2'd1) return 20;
    return mm ? 24 : 20;
  endfunction

  function automatic logic [143:0] mkvals(input logic [23:0] seed);
    logic [143:0] r;
    for (int k = 0; k < 6; k++) r[k*24 +: 24] = seed * 24'(k + 3) ^ 24'h9E3779 + 24'(k * 24'h111111);
    return r;
  endfunction

  function automatic logic [143:0] expect_of(input logic [143:0] v, input bit mm, input logic [1:0] w);
    logic [143:0] e;
    int wb = wbits(mm, w);
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 24; i++)
        e[k*24+i] = (i < wb) ? v[k*24+i] : v[k*24+wb-1];
    return e;
  endfunction

  task automatic bit_out(input logic lr, input logic d);
    bclk = 1'b0; lrclk = lr; sdat = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset(input bit mm, input logic [1:0] w);
    rst = 1'b1; m256 = mm; wl = w; bclk = 1'b0; sdat = 1'b0;
    lrclk = mm;  // level of the right group
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) bit_out(mm, 1'b0);
  endtask

  // nbits: bits driven; past the frame length the right-group level is held
  task automatic send_frame(input logic [143:0] v, input bit junk, input int nbits);
    logic fb [256];
    int   len = m256 ? 256 : 128;
    int   wb  = wbits(m256, wl);
    int   dly = m256 ? 1 : 0;
    int   base;
    for (int p = 0; p < 256; p++) fb[p] = junk;
    for (int k = 0; k < 6; k++) begin
      base = m256 ? ((k < 3) ? k*32 : 128 + (k-3)*32) : ((k < 3) ? k*20 : 64 + (k-3)*20);
      for (int i = 0; i < wb; i++) fb[base+dly+i] = v[k*24 + wb-1-i];
    end
    for (int p = 0; p < nbits; p++) begin
      logic lr;
      if (p >= len) lr = m256;
      else if (m256) lr = (p >= 128);
      else lr = (p < 64);
      bit_out(lr, (p < len) ? fb[p] : 1'b0);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_samples(input logic [143:0] exp, input string req);
    for (int k = 0; k < 6; k++)
      chk(got[k*24 +: 24] == exp[k*24 +: 24], req, 64'(got[k*24 +: 24]), 64'(exp[k*24 +: 24]));
  endtask

  task automatic t_reset;
    rst = 1'b1; bclk = 1'b0; lrclk = 1'b1; sdat = 1'b1;
    repeat (4) @(negedge clk);
    chk(valid == 1'b0 && ferr == 1'b0, "R1 strobes in reset", 64'({valid, ferr}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(smp == '0, "R1 samples after reset", 64'(smp[63:0]), 64'd0);
    chk(valid == 1'b0 && ferr == 1'b0, "R1 strobes after reset", 64'({valid, ferr}), 64'd0);
  endtask

  task automatic t_format(input bit mm, input logic [1:0] w, input bit junk, input logic [23:0] seed, input string req);
    int v0, e0;
    logic [143:0] a, b;
    do_reset(mm, w);
    v0 = vcnt; e0 = ecnt;
    a = mkvals(seed); b = mkvals(seed ^ 24'hF0F0F1);
    send_frame(a, junk, mm ? 256 : 128);
    chk(vcnt == v0 + 1, {req, " first frame valid"}, 64'(vcnt - v0), 64'd1);
    chk_samples(expect_of(a, mm, w), {req, " first frame words"});
    send_frame(b, junk, mm ? 256 : 128);
    chk(vcnt == v0 + 2, {"R6 ", req, " one valid per frame"}, 64'(vcnt - v0), 64'd2);
    chk_samples(expect_of(b, mm, w), {req, " second frame words"});
    chk(ecnt == e0, {"R9 ", req, " no error"}, 64'(ecnt - e0), 64'd0);
  endtask

  task automatic t_early;
    int v0, e0;
    logic [143:0] a, c;
    do_reset(1'b0, 2'd1);
    v0 = vcnt; e0 = ecnt;
    a = mkvals(24'h123457); c = mkvals(24'h0BCDEF);
    send_frame(a, 1'b0, 128);
    send_frame(mkvals(24'h777777), 1'b0, 100);
    chk(vcnt == v0 + 1, "R8 short frame gives no valid", 64'(vcnt - v0), 64'd1);
    send_frame(c, 1'b0, 128);
    chk(ecnt == e0 + 1, "R8 early start flagged", 64'(ecnt - e0), 64'd1);
    chk(vcnt == v0 + 2, "R8 frame after error valid", 64'(vcnt - v0), 64'd2);
    chk_samples(expect_of(c, 1'b0, 2'd1), "R8 words after error");
  endtask

  task automatic t_long;
    int v0, e0;
    logic [143:0] a, c;
    do_reset(1'b1, 2'd2);
    v0 = vcnt; e0 = ecnt;
    a = mkvals(24'h2468AC); c = mkvals(24'h13579B);
    send_frame(a, 1'b0, 256 + 5);
    chk(ecnt == e0 + 1, "R9 overlong frame flagged", 64'(ecnt - e0), 64'd1);
    send_frame(c, 1'b0, 256);
    chk(ecnt == e0 + 1, "R9 relock without error", 64'(ecnt - e0), 64'd1);
    chk(vcnt == v0 + 2, "R9 valid after relock", 64'(vcnt - v0), 64'd2);
    chk_samples(expect_of(c, 1'b1, 2'd2), "R9 words after relock");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_format(1'b0, 2'd1, 1'b0, 24'h8A5C31, "R2 R3 128/20");
    t_format(1'b0, 2'd0, 1'b0, 24'hC0FFEE, "R3 128/16");
    t_format(1'b0, 2'd2, 1'b0, 24'hD1CE55, "R4 128/24 limited");
    t_format(1'b1, 2'd2, 1'b0, 24'hBEEF01, "R5 256/24");
    t_format(1'b1, 2'd0, 1'b0, 24'h5A5A5B, "R5 256/16");
    t_format(1'b1, 2'd1, 1'b1, 24'h31415A, "R7 R5 256/20 junk");
    t_format(1'b0, 2'd0, 1'b1, 24'h271828, "R7 128/16 junk");
    t_early();
    t_long();
    chk(dbl == 0, "R6 valid lasts one cycle", 64'(dbl), 64'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule